// File: doc/BRIEF.md
# Legacy Region Address Decoder

This block classifies every host memory access in the 32-bit space and names the port that must serve it: system DRAM, the graphics PCI Express port, or the downstream I/O hub port. For each request the host interface presents the address, a write flag and a flag that says whether the processor is in system management mode. A registered target code comes back one clock later.

The routing is set by configuration inputs. The 768 KB to 1 MB compatibility area is split into thirteen shadow segments. Each segment has a 2-bit attribute that routes reads and writes on their own, so one address can be read from DRAM and written to the hub. A 5-bit top-of-low-memory field gives the DRAM ceiling in 128 MB steps. An optional hole at 15–16 MB can be switched on. The legacy video/SMM window at A0000h–BFFFFh is handled, and so is the fixed I/O interrupt controller range at FEC0_0000h–FEC7_FFFFh. A graphics bridge window is set by a base/limit pair with 1 MB granularity. When several of these regions cover one address, a fixed priority decides.

Top module: `legacy_region_decoder`

## Requirements
- R1: A request with `req_valid` high in one cycle gives `rsp_valid` high in the next cycle, with the decision for that request on `rsp_target`. A cycle with no request gives `rsp_valid` low in the next cycle and leaves `rsp_target` unchanged.
- R2: Target codes are 0 = DRAM, 1 = graphics port, 2 = hub port. Code 3 never appears. In reset, `rsp_valid` is 0 and `rsp_target` is 2.
- R3: Shadow segments: segments 0–11 are the 16 KB blocks from C0000h to EFFFFh, numbered upward from C0000h. Segment 12 is the 64 KB block F0000h–FFFFFh. Segment n uses bits [2n+1:2n] of `cfg_shadow_attr`. Bit 2n routes reads and bit 2n+1 routes writes: 1 sends the access to DRAM and 0 sends it to the hub port.
- R4: With attribute 01 a read goes to DRAM and a write to the same address goes to the hub. With attribute 10 the routing is the other way round.
- R5: An access in A0000h–BFFFFh goes to DRAM when `cfg_smm_en` is 1 and either `cfg_smm_open` or `req_smm` is 1. Otherwise it goes to the graphics port if `cfg_vga_gfx` is 1, or else to the hub port.
- R6: An address whose bits [31:27] are at most `cfg_tolm` goes to DRAM, so the DRAM ceiling is (`cfg_tolm`+1) × 128 MB. Addresses at or above the ceiling fall to the lower-priority rules.
- R7: When `cfg_hole_en` is 1, any address in F0_0000h–FF_FFFFh goes to the hub port, even below the DRAM ceiling. When it is 0, that range decodes like any other DRAM address.
- R8: Any address in FEC0_0000h–FEC7_FFFFh goes to the hub port. This wins over every other rule, the bridge window included.
- R9: An address with bits [31:20] from `cfg_br_base` to `cfg_br_limit`, both ends included, goes to the graphics port. This wins over the DRAM ceiling.
- R10: Priority is fixed, highest first: interrupt-controller range, A0000h–BFFFFh window, shadow segments, 15–16 MB hole, bridge window, DRAM ceiling, and the hub port as the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Processor in system management mode |
| cfg_shadow_attr | input | 26 | Two attribute bits per shadow segment |
| cfg_tolm | input | 5 | DRAM ceiling in 128 MB steps, minus one |
| cfg_hole_en | input | 1 | Enable the 15–16 MB hole |
| cfg_smm_en | input | 1 | SMM DRAM space enabled |
| cfg_smm_open | input | 1 | SMM DRAM space open to non-SMM accesses |
| cfg_vga_gfx | input | 1 | Legacy video window routed to the graphics port |
| cfg_br_base | input | 12 | Bridge window base, address bits [31:20] |
| cfg_br_limit | input | 12 | Bridge window limit, address bits [31:20] |
| rsp_valid | output | 1 | Decision valid |
| rsp_target | output | 2 | Target code |

## Verification
The interesting collisions are between the bridge window and the other regions in one decision. The bench sets base/limit so the window covers DRAM below the ceiling, and expects the graphics code. It then moves the window over the interrupt-controller range, where the hub code must win inside that range and the graphics code just outside it. It also moves the window onto the video window, where the video routing must win. Each collision is judged by the single target code seen one cycle after the request.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_GFX  = 2'd1,
    TGT_HUB  = 2'd2
  } tgt_e;

  localparam int SHADOW_SEGS = 13;
endpackage

// File: rtl/lrd_range.sv
// Inclusive window compare on an address slice.
module lrd_range #(
  parameter int W = 12
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         in_range
);
  always_comb begin
    in_range = (value >= lo) && (value <= hi);
  end
endmodule

// File: rtl/lrd_shadow.sv
// Compatibility area segment match and per-direction attribute select.
module lrd_shadow #(
  parameter int SEGS = lrd_pkg::SHADOW_SEGS
) (
  input  logic [31:0]       addr,
  input  logic              write,
  input  logic [2*SEGS-1:0] attr,
  output logic              hit,
  output logic              to_dram
);
  localparam int SMALL_SEGS = SEGS - 1;

  logic [SEGS-1:0] seg_match;
  logic [SEGS-1:0] seg_permit;
  logic            in_area;
  logic            top_block;

  always_comb begin
    in_area   = (addr[31:20] == 12'h000) && (addr[19:18] == 2'b11);
    top_block = (addr[19:16] == 4'hF);
  end

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    if (g < SMALL_SEGS) begin : g_small
      always_comb begin
        seg_match[g] = in_area && !top_block && (addr[17:14] == 4'(g));
      end
    end else begin : g_top
      always_comb begin
        seg_match[g] = in_area && top_block;
      end
    end
    always_comb begin
      seg_permit[g] = write ? attr[2*g+1] : attr[2*g];
    end
  end

  always_comb begin
    hit     = in_area;
    to_dram = |(seg_match & seg_permit);
  end
endmodule

// File: rtl/lrd_prio.sv
// Fixed-priority selection among region hits.
module lrd_prio
  import lrd_pkg::*;
(
  input  logic apic_hit,
  input  logic legacy_hit,
  input  logic legacy_dram,
  input  logic vga_gfx,
  input  logic shadow_hit,
  input  logic shadow_dram,
  input  logic hole_hit,
  input  logic bridge_hit,
  input  logic below_ceiling,
  output tgt_e target
);
  always_comb begin
    if (apic_hit) begin
      target = TGT_HUB;
    end else if (legacy_hit) begin
      if (legacy_dram)  target = TGT_DRAM;
      else if (vga_gfx) target = TGT_GFX;
      else              target = TGT_HUB;
    end else if (shadow_hit) begin
      target = shadow_dram ? TGT_DRAM : TGT_HUB;
    end else if (hole_hit) begin
      target = TGT_HUB;
    end else if (bridge_hit) begin
      target = TGT_GFX;
    end else if (below_ceiling) begin
      target = TGT_DRAM;
    end else begin
      target = TGT_HUB;
    end
  end
endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
  import lrd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEGS   = SHADOW_SEGS,
  parameter int CEIL_W = 5,
  parameter int BR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  input  logic [2*SEGS-1:0] cfg_shadow_attr,
  input  logic [CEIL_W-1:0] cfg_tolm,
  input  logic              cfg_hole_en,
  input  logic              cfg_smm_en,
  input  logic              cfg_smm_open,
  input  logic              cfg_vga_gfx,
  input  logic [BR_W-1:0]   cfg_br_base,
  input  logic [BR_W-1:0]   cfg_br_limit,
  output logic              rsp_valid,
  output logic [1:0]        rsp_target
);
  localparam int CEIL_LSB   = ADDR_W - CEIL_W;
  localparam int BR_LSB     = ADDR_W - BR_W;
  localparam int APIC_LSB   = 19;
  localparam int LEGACY_LSB = 17;
  localparam int HOLE_LSB   = 20;
  localparam logic [ADDR_W-APIC_LSB-1:0]   APIC_KEY   = (ADDR_W-APIC_LSB)'(32'hFEC0_0000 >> APIC_LSB);
  localparam logic [ADDR_W-LEGACY_LSB-1:0] LEGACY_KEY = (ADDR_W-LEGACY_LSB)'(32'h000A_0000 >> LEGACY_LSB);
  localparam logic [ADDR_W-HOLE_LSB-1:0]   HOLE_KEY   = (ADDR_W-HOLE_LSB)'(32'h00F0_0000 >> HOLE_LSB);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Region matches
  logic apic_hit, legacy_hit, hole_win, bridge_hit;
  logic shadow_hit, shadow_dram;
  logic below_ceiling, legacy_dram, hole_hit;
  tgt_e target_d;

  lrd_range #(.W(ADDR_W-APIC_LSB)) u_apic (
    .value(req_addr[ADDR_W-1:APIC_LSB]), .lo(APIC_KEY), .hi(APIC_KEY), .in_range(apic_hit)
  );

  lrd_range #(.W(ADDR_W-LEGACY_LSB)) u_legacy (
    .value(req_addr[ADDR_W-1:LEGACY_LSB]), .lo(LEGACY_KEY), .hi(LEGACY_KEY), .in_range(legacy_hit)
  );

  lrd_range #(.W(ADDR_W-HOLE_LSB)) u_hole (
    .value(req_addr[ADDR_W-1:HOLE_LSB]), .lo(HOLE_KEY), .hi(HOLE_KEY), .in_range(hole_win)
  );

  lrd_range #(.W(BR_W)) u_bridge (
    .value(req_addr[ADDR_W-1:BR_LSB]), .lo(cfg_br_base), .hi(cfg_br_limit), .in_range(bridge_hit)
  );

  lrd_shadow #(.SEGS(SEGS)) u_shadow (
    .addr(req_addr[31:0]), .write(req_write), .attr(cfg_shadow_attr),
    .hit(shadow_hit), .to_dram(shadow_dram)
  );

  always_comb begin
    below_ceiling = (req_addr[ADDR_W-1:CEIL_LSB] <= cfg_tolm);
    legacy_dram   = cfg_smm_en && (cfg_smm_open || req_smm);
    hole_hit      = cfg_hole_en && hole_win;
  end

  lrd_prio u_prio (
    .apic_hit(apic_hit), .legacy_hit(legacy_hit), .legacy_dram(legacy_dram),
    .vga_gfx(cfg_vga_gfx), .shadow_hit(shadow_hit), .shadow_dram(shadow_dram),
    .hole_hit(hole_hit), .bridge_hit(bridge_hit), .below_ceiling(below_ceiling),
    .target(target_d)
  );

  // Output stage
  logic valid_q;
  tgt_e target_q;
  logic valid_d;
  tgt_e target_n;

  always_comb begin
    valid_d  = req_valid;
    target_n = req_valid ? target_d : target_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      target_q <= TGT_HUB;
    end else begin
      valid_q  <= valid_d;
      target_q <= target_n;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_target = target_q;
endmodule

// File: rtl/lrd_checks.sv
module lrd_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic [25:0] cfg_shadow_attr,
  input logic        cfg_hole_en,
  input logic        rsp_valid,
  input logic [1:0]  rsp_target
);
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r1_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_target));

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_target != 2'd3);

  a_r8_apic_hub: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:19] == 13'h1FD8) |=> rsp_target == 2'd2);

  a_r7_hole_hub: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_hole_en && req_addr[31:20] == 12'h00F) |=> rsp_target == 2'd2);

  a_r3_closed_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_shadow_attr == 26'd0 && req_addr[31:18] == 14'h0003)
      |=> rsp_target == 2'd2);
endmodule

bind legacy_region_decoder lrd_checks u_lrd_checks (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_addr(req_addr),
  .cfg_shadow_attr(cfg_shadow_attr), .cfg_hole_en(cfg_hole_en),
  .rsp_valid(rsp_valid), .rsp_target(rsp_target)
);

// File: tb/test_legacy_region_decoder.sv
module test_legacy_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        req_smm;
  logic [25:0] cfg_shadow_attr;
  logic [4:0]  cfg_tolm;
  logic        cfg_hole_en, cfg_smm_en, cfg_smm_open, cfg_vga_gfx;
  logic [11:0] cfg_br_base, cfg_br_limit;
  logic        rsp_valid;
  logic [1:0]  rsp_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2ns clk = ~clk;

  legacy_region_decoder i_legacy_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_smm(req_smm), .cfg_shadow_attr(cfg_shadow_attr),
    .cfg_tolm(cfg_tolm), .cfg_hole_en(cfg_hole_en), .cfg_smm_en(cfg_smm_en),
    .cfg_smm_open(cfg_smm_open), .cfg_vga_gfx(cfg_vga_gfx),
    .cfg_br_base(cfg_br_base), .cfg_br_limit(cfg_br_limit),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target)
  );

  // {req tag, addr, write, smm, expected target}; 0 DRAM, 1 GFX, 2 HUB
  localparam int NVEC = 21;
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd6,  32'h0000_1000, 1'b0, 1'b0, 2'd0},  // R6 low DRAM
    {4'd3,  32'h000C_0000, 1'b0, 1'b0, 2'd2},  // R3 seg0 attr 00
    {4'd4,  32'h000C_4000, 1'b0, 1'b0, 2'd0},  // R4 seg1 01 read
    {4'd4,  32'h000C_7FFF, 1'b1, 1'b0, 2'd2},  // R4 seg1 01 write
    {4'd4,  32'h000C_8000, 1'b0, 1'b0, 2'd2},  // R4 seg2 10 read
    {4'd4,  32'h000C_8000, 1'b1, 1'b0, 2'd0},  // R4 seg2 10 write
    {4'd3,  32'h000C_C000, 1'b1, 1'b0, 2'd0},  // R3 seg3 11
    {4'd3,  32'h000E_C000, 1'b0, 1'b0, 2'd0},  // R3 seg11 11
    {4'd3,  32'h000E_8000, 1'b0, 1'b0, 2'd2},  // R3 seg10 10 read
    {4'd3,  32'h000F_8000, 1'b1, 1'b0, 2'd0},  // R3 seg12 11
    {4'd5,  32'h000A_0000, 1'b0, 1'b0, 2'd1},  // R5 closed, video to gfx
    {4'd5,  32'h000B_FFFF, 1'b0, 1'b1, 2'd0},  // R5 smm mode
    {4'd6,  32'h0009_FFFF, 1'b0, 1'b0, 2'd0},  // R6 just below window
    {4'd7,  32'h00F0_0000, 1'b0, 1'b0, 2'd2},  // R7 hole start
    {4'd7,  32'h00FF_FFFF, 1'b1, 1'b0, 2'd2},  // R7 hole end
    {4'd7,  32'h00EF_FFFF, 1'b0, 1'b0, 2'd0},  // R7 below hole
    {4'd9,  32'h1800_0000, 1'b0, 1'b0, 2'd1},  // R9 bridge base
    {4'd9,  32'h1FFF_FFFF, 1'b1, 1'b0, 2'd1},  // R9 bridge limit
    {4'd6,  32'h2000_0000, 1'b0, 1'b0, 2'd2},  // R6 at ceiling -> default
    {4'd8,  32'hFEC0_0000, 1'b0, 1'b0, 2'd2},  // R8 apic low
    {4'd8,  32'hFEC7_FFFF, 1'b1, 1'b0, 2'd2}   // R8 apic high
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [31:0] a, input logic w,
                       input logic s, input logic [1:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_smm = s;
    @(negedge clk);
    check($sformatf("%s addr=%08h valid", tag, a), {1'b0, rsp_valid}, 2'd1);
    check($sformatf("%s addr=%08h target", tag, a), rsp_target, exp);
  endtask

  task automatic base_cfg();
    for (int i = 0; i < 13; i++) cfg_shadow_attr[2*i +: 2] = 2'(i % 4);
    cfg_shadow_attr[25:24] = 2'b11;
    cfg_tolm = 5'd3;
    cfg_hole_en = 1'b1; cfg_smm_en = 1'b1; cfg_smm_open = 1'b0; cfg_vga_gfx = 1'b1;
    cfg_br_base = 12'h180; cfg_br_limit = 12'h1FF;
  endtask

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_smm = 1'b0;
    base_cfg();
    repeat (3) @(negedge clk);
    check("R2 reset valid", {1'b0, rsp_valid}, 2'd0);
    check("R2 reset target", rsp_target, 2'd2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      issue($sformatf("R%0d vec%0d", VEC[k][39:36], k), VEC[k][35:4], VEC[k][3], VEC[k][2], VEC[k][1:0]);
    end

    // R1 idle cycle: no valid, target held from last request (hub)
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h0000_2000;
    @(negedge clk);
    check("R1 idle valid", {1'b0, rsp_valid}, 2'd0);
    check("R1 idle hold", rsp_target, 2'd2);

    // R6 ceiling extremes
    cfg_tolm = 5'd0;
    issue("R6 tolm0 last", 32'h07FF_FFFF, 1'b0, 1'b0, 2'd0);
    issue("R6 tolm0 above", 32'h0800_0000, 1'b0, 1'b0, 2'd2);
    cfg_tolm = 5'd31;
    issue("R6 tolm31 top", 32'hF000_0000, 1'b0, 1'b0, 2'd0);
    cfg_tolm = 5'd3;

    // R7 hole disabled
    cfg_hole_en = 1'b0;
    issue("R7 hole off", 32'h00F8_0000, 1'b0, 1'b0, 2'd0);

    // R5 variants
    cfg_smm_open = 1'b1;
    issue("R5 open", 32'h000A_8000, 1'b1, 1'b0, 2'd0);
    cfg_smm_open = 1'b0; cfg_smm_en = 1'b0; cfg_vga_gfx = 1'b0;
    issue("R5 disabled smm mode", 32'h000B_0000, 1'b0, 1'b1, 2'd2);

    // R10 video window beats bridge window
    cfg_br_base = 12'h000; cfg_br_limit = 12'h000;
    issue("R10 window over bridge", 32'h000A_0000, 1'b0, 1'b0, 2'd2);
    issue("R10 bridge over dram", 32'h0000_1000, 1'b0, 1'b0, 2'd1);

    // R8 apic beats bridge window
    cfg_br_base = 12'hFE0; cfg_br_limit = 12'hFEF;
    issue("R8 apic in bridge", 32'hFEC4_0000, 1'b0, 1'b0, 2'd2);
    issue("R9 beside apic", 32'hFEC8_0000, 1'b0, 1'b0, 2'd1);
    issue("R9 above limit", 32'hFF00_0000, 1'b0, 1'b0, 2'd2);

    // R3 all segments closed
    cfg_shadow_attr = '0;
    issue("R3 closed top seg", 32'h000F_0000, 1'b1, 1'b0, 2'd2);

    @(negedge clk);
    req_valid = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule